// File: doc/BRIEF.md
# Four-Channel Buffered DMA Engine

This block moves blocks of bytes from a source address range to a destination address range over a single-master memory bus. It has four channels. Each channel has its own source address, destination address, byte count and control word. A configuration write port loads these registers. Every move goes through a 16-byte staging buffer. The engine first fills the buffer with reads of the source width. It then drains the buffer with writes of the destination width. One fill and drain pair is called a chunk.

Each channel starts on a rising edge of its own request input. In continuous mode one edge runs the channel to completion. In cycle-steal mode each edge moves exactly one chunk. Channels are arbitrated only when the engine is between chunks. The default is fixed priority, and a round-robin input can select rotating priority instead. An auto-align option lets a channel start at any byte address with any count. Per-channel status outputs report busy, done, configuration error and bus error, together with a level interrupt.

Top module: `dma4_buf_engine`

## Requirements
- R1: After reset no channel is busy, done or in error, no interrupt is raised and `mem_req` is low.
- R2: Size code 0, 1, 2 and 3 stand for 1, 2, 4 and 16 bytes. Bus data sits in the low bytes of the 128-bit data buses, lowest address in bits 7:0. The destination range receives an exact byte copy of the source range.
- R3: The source and destination sizes are independent. A chunk is the larger of the two sizes. It is read with source-size accesses and written with destination-size accesses, and every access address is a multiple of its size.
- R4: The count drops by the bytes written. When it reaches zero the channel clears busy and sets done. Its interrupt is raised if control bit 7 is set.
- R5: Writing control with bit 0 (enable) set gives a configuration error if the count is zero. With auto-align off it also gives a configuration error if the count is not a multiple of the chunk size, or if either address is not a multiple of its own size. A channel in configuration error stays idle and issues no bus access.
- R6: With control bit 1 set (continuous), one request edge moves the whole count.
- R7: With control bit 1 clear (cycle-steal), each request edge moves exactly one chunk.
- R8: A new grant is issued only between chunks. The accesses of one chunk are never interleaved with those of another channel. With `rr_en` low, the lowest-numbered eligible channel wins.
- R9: With `rr_en` high, the search starts at the channel after the last one granted, wrapping after channel 3.
- R10: With control bit 6 (auto-align) set, any nonzero count is accepted. A chunk is the smaller of the chunk size and the remaining count. Each access uses the largest size that does not exceed the programmed size, is aligned at the current address and fits in the rest of the chunk.
- R11: A request edge on a channel that is not armed is dropped and not remembered.
- R12: A bus access acknowledged with `mem_err` stops the channel. It sets bus error, leaves done clear and issues no further access.
- R13: Any write to a channel's control word clears its done flag, error flags and interrupt. Control bits 5:4 give the destination size and bits 3:2 the source size. Register selects are 0 source, 1 destination, 2 count and 3 control.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rr_en | input | 1 | Round-robin arbitration when high |
| dreq | input | 4 | Per-channel request, acts on a rising edge |
| cfg_we | input | 1 | Register write strobe |
| cfg_ch | input | 2 | Channel addressed by the write |
| cfg_sel | input | 2 | Register select (0 src, 1 dst, 2 count, 3 control) |
| cfg_wdata | input | 32 | Register write data |
| mem_req | output | 1 | Bus access request, held until acknowledged |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 32 | Byte address of the access |
| mem_size | output | 2 | Access size code |
| mem_wdata | output | 128 | Write data, low bytes used |
| mem_rdata | input | 128 | Read data, low bytes used |
| mem_ack | input | 1 | Access completes in this cycle |
| mem_err | input | 1 | The completing access failed |
| ch_busy | output | 4 | Channel armed |
| ch_done | output | 4 | Channel finished its count |
| ch_cfg_err | output | 4 | Channel rejected its programming |
| ch_bus_err | output | 4 | Channel stopped on a bus error |
| ch_irq | output | 4 | Done interrupt per channel |

## Verification
A corrupted fill or drain pointer shows at the ports within one chunk. The destination bytes come out shifted or repeated, or an access size that overruns the buffer shows on `mem_size` in the chunk where the error happens. A wrong count or a stuck arm flag shows as done rising one chunk too early or too late. A cycle-steal channel that moves more than one chunk per edge shows as extra writes before the next request. A broken arbiter shows in the order of destination addresses on the write bus at the very next chunk boundary. The bench therefore logs every acknowledged access and compares the sequence and the sizes, not only the final memory image.

// File: rtl/dma4_pkg.sv
package dma4_pkg;

  localparam int BUF_BYTES = 16;
  localparam int DATA_W    = 8 * BUF_BYTES;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_READ,
    ST_WRITE,
    ST_WBACK
  } eng_state_t;

  // control word, MSB first: bit7 irq_en .. bit0 en
  typedef struct packed {
    logic       irq_en;
    logic       align;
    logic [1:0] dsz;
    logic [1:0] ssz;
    logic       cont;
    logic       en;
  } ctrl_t;

  function automatic logic [4:0] size_bytes(input logic [1:0] code);
    case (code)
      2'd0:    return 5'd1;
      2'd1:    return 5'd2;
      2'd2:    return 5'd4;
      default: return 5'd16;
    endcase
  endfunction

  // largest size code not above prog, aligned at alo, not above rem bytes
  function automatic logic [1:0] pick_size(input logic [3:0] alo,
                                           input logic [1:0] prog,
                                           input logic [4:0] rem);
    logic [1:0] best;
    logic [4:0] b;
    best = 2'd0;
    for (int e = 1; e < 4; e++) begin
      b = size_bytes(2'(e));
      if (2'(e) <= prog && (alo & 4'(b - 5'd1)) == 4'd0 && b <= rem)
        best = 2'(e);
    end
    return best;
  endfunction

endpackage

// File: rtl/dma4_arb.sv
module dma4_arb #(
  parameter int NCH = 4,
  parameter int CHW = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] req,
  input  logic           rr_en,
  input  logic           take,
  output logic [NCH-1:0] gnt
);

  logic [CHW-1:0] last_q, last_n;
  logic           found;

  always_comb begin
    gnt   = '0;
    found = 1'b0;
    if (rr_en) begin
      for (int k = 1; k <= NCH; k++) begin
        if (!found && req[(int'(last_q) + k) % NCH]) begin
          gnt[(int'(last_q) + k) % NCH] = 1'b1;
          found = 1'b1;
        end
      end
    end else begin
      for (int k = 0; k < NCH; k++) begin
        if (!found && req[k]) begin
          gnt[k] = 1'b1;
          found  = 1'b1;
        end
      end
    end
  end

  always_comb begin
    last_n = last_q;
    if (take) begin
      for (int k = 0; k < NCH; k++) begin
        if (gnt[k]) last_n = CHW'(k);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_q <= CHW'(NCH - 1);
    else        last_q <= last_n;
  end

  // R8
  gnt_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|req) |-> ($onehot(gnt) && (gnt & ~req) == '0));

endmodule

// File: rtl/dma4_chan.sv
module dma4_chan
  import dma4_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [1:0]    wr_sel,
  input  logic [AW-1:0] wr_data,
  input  logic          dreq,
  input  logic          gnt,
  input  logic          wb_valid,
  input  logic [AW-1:0] wb_src,
  input  logic [AW-1:0] wb_dst,
  input  logic [CW-1:0] wb_cnt,
  input  logic          wb_err,
  output logic [AW-1:0] src,
  output logic [AW-1:0] dst,
  output logic [CW-1:0] cnt,
  output ctrl_t         ctrl,
  output logic          elig,
  output logic          done,
  output logic          cfg_err,
  output logic          bus_err,
  output logic          busy,
  output logic          irq
);

  logic [AW-1:0] src_q, src_n, dst_q, dst_n;
  logic [CW-1:0] cnt_q, cnt_n;
  ctrl_t         ctrl_q, ctrl_n, new_ctrl;
  logic armed_q, armed_n, pend_q, pend_n, run_q, run_n;
  logic done_q, done_n, cerr_q, cerr_n, berr_q, berr_n, dreq_q;
  logic [4:0] sb, db, mb;
  logic       bad_cfg;

  // programming check on the control word being written
  always_comb begin
    new_ctrl = ctrl_t'(wr_data[7:0]);
    sb       = size_bytes(new_ctrl.ssz);
    db       = size_bytes(new_ctrl.dsz);
    mb       = (sb > db) ? sb : db;
    bad_cfg  = (cnt_q == '0) ||
               (!new_ctrl.align &&
                (((cnt_q[4:0] & (mb - 5'd1)) != 5'd0) ||
                 ((src_q[3:0] & 4'(sb - 5'd1)) != 4'd0) ||
                 ((dst_q[3:0] & 4'(db - 5'd1)) != 4'd0)));
  end

  always_comb begin
    src_n   = src_q;
    dst_n   = dst_q;
    cnt_n   = cnt_q;
    ctrl_n  = ctrl_q;
    armed_n = armed_q;
    pend_n  = pend_q;
    run_n   = run_q;
    done_n  = done_q;
    cerr_n  = cerr_q;
    berr_n  = berr_q;
    if (dreq && !dreq_q && armed_q) pend_n = 1'b1;
    if (gnt) begin
      pend_n = 1'b0;
      if (ctrl_q.cont) run_n = 1'b1;
    end
    if (wb_valid) begin
      src_n = wb_src;
      dst_n = wb_dst;
      cnt_n = wb_cnt;
      if (wb_err || wb_cnt == '0) begin
        armed_n = 1'b0;
        run_n   = 1'b0;
        pend_n  = 1'b0;
        if (wb_err) berr_n = 1'b1;
        else        done_n = 1'b1;
      end
    end
    if (wr_en) begin
      case (wr_sel)
        2'd0: src_n = wr_data;
        2'd1: dst_n = wr_data;
        2'd2: cnt_n = wr_data[CW-1:0];
        default: begin
          ctrl_n  = new_ctrl;
          done_n  = 1'b0;
          berr_n  = 1'b0;
          pend_n  = 1'b0;
          run_n   = 1'b0;
          cerr_n  = new_ctrl.en && bad_cfg;
          armed_n = new_ctrl.en && !bad_cfg;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q   <= '0;
      dst_q   <= '0;
      cnt_q   <= '0;
      ctrl_q  <= '0;
      armed_q <= 1'b0;
      pend_q  <= 1'b0;
      run_q   <= 1'b0;
      done_q  <= 1'b0;
      cerr_q  <= 1'b0;
      berr_q  <= 1'b0;
      dreq_q  <= 1'b0;
    end else begin
      src_q   <= src_n;
      dst_q   <= dst_n;
      cnt_q   <= cnt_n;
      ctrl_q  <= ctrl_n;
      armed_q <= armed_n;
      pend_q  <= pend_n;
      run_q   <= run_n;
      done_q  <= done_n;
      cerr_q  <= cerr_n;
      berr_q  <= berr_n;
      dreq_q  <= dreq;
    end
  end

  assign src     = src_q;
  assign dst     = dst_q;
  assign cnt     = cnt_q;
  assign ctrl    = ctrl_q;
  assign elig    = armed_q && (pend_q || run_q);
  assign done    = done_q;
  assign cfg_err = cerr_q;
  assign bus_err = berr_q;
  assign busy    = armed_q;
  assign irq     = done_q && ctrl_q.irq_en;

  // R4
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> !armed_q);

  // R5
  cfg_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cerr_q |-> (!armed_q && !pend_q));

  // R11
  pend_armed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q |-> armed_q);

  // R7
  steal_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt && !ctrl_q.cont && !wr_en) |=> !run_q);

endmodule

// File: rtl/dma4_engine.sv
module dma4_engine
  import dma4_pkg::*;
#(
  parameter int AW  = 32,
  parameter int CW  = 16,
  parameter int CHW = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [CHW-1:0]    start_ch,
  input  logic [AW-1:0]     ld_src,
  input  logic [AW-1:0]     ld_dst,
  input  logic [CW-1:0]     ld_cnt,
  input  logic [1:0]        ld_ssz,
  input  logic [1:0]        ld_dsz,
  input  logic              ld_align,
  output logic              idle,
  output logic              mem_req,
  output logic              mem_we,
  output logic [AW-1:0]     mem_addr,
  output logic [1:0]        mem_size,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              mem_ack,
  input  logic              mem_err,
  output logic              wb_valid,
  output logic [CHW-1:0]    wb_ch,
  output logic [AW-1:0]     wb_src,
  output logic [AW-1:0]     wb_dst,
  output logic [CW-1:0]     wb_cnt,
  output logic              wb_err
);

  eng_state_t    st_q, st_n;
  logic [CHW-1:0] ch_q, ch_n;
  logic [AW-1:0] src_q, src_n, dst_q, dst_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic [1:0]    ssz_q, ssz_n, dsz_q, dsz_n;
  logic [4:0]    rrem_q, rrem_n, wrem_q, wrem_n;
  logic [3:0]    fill_q, fill_n, drain_q, drain_n;
  logic          err_q, err_n;
  logic [7:0]    buf_q [BUF_BYTES];
  logic [1:0]    acc_sz;
  logic [4:0]    acc_b, sb, db, mb, chunk;
  logic          buf_we;

  always_comb begin
    sb    = size_bytes(ld_ssz);
    db    = size_bytes(ld_dsz);
    mb    = (sb > db) ? sb : db;
    chunk = (ld_align && ld_cnt < CW'(mb)) ? ld_cnt[4:0] : mb;
  end

  always_comb begin
    if (st_q == ST_READ) acc_sz = pick_size(src_q[3:0], ssz_q, rrem_q);
    else                 acc_sz = pick_size(dst_q[3:0], dsz_q, wrem_q);
    acc_b = size_bytes(acc_sz);
  end

  always_comb begin
    st_n    = st_q;
    ch_n    = ch_q;
    src_n   = src_q;
    dst_n   = dst_q;
    cnt_n   = cnt_q;
    ssz_n   = ssz_q;
    dsz_n   = dsz_q;
    rrem_n  = rrem_q;
    wrem_n  = wrem_q;
    fill_n  = fill_q;
    drain_n = drain_q;
    err_n   = err_q;
    buf_we  = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (start) begin
          st_n    = ST_READ;
          ch_n    = start_ch;
          src_n   = ld_src;
          dst_n   = ld_dst;
          cnt_n   = ld_cnt;
          ssz_n   = ld_ssz;
          dsz_n   = ld_dsz;
          rrem_n  = chunk;
          wrem_n  = chunk;
          fill_n  = 4'd0;
          drain_n = 4'd0;
          err_n   = 1'b0;
        end
      end
      ST_READ: begin
        if (mem_ack) begin
          if (mem_err) begin
            err_n = 1'b1;
            st_n  = ST_WBACK;
          end else begin
            buf_we = 1'b1;
            src_n  = src_q + AW'(acc_b);
            fill_n = fill_q + acc_b[3:0];
            rrem_n = rrem_q - acc_b;
            if (rrem_q == acc_b) begin
              st_n    = ST_WRITE;
              drain_n = 4'd0;
            end
          end
        end
      end
      ST_WRITE: begin
        if (mem_ack) begin
          if (mem_err) begin
            err_n = 1'b1;
            st_n  = ST_WBACK;
          end else begin
            dst_n   = dst_q + AW'(acc_b);
            cnt_n   = cnt_q - CW'(acc_b);
            wrem_n  = wrem_q - acc_b;
            drain_n = drain_q + acc_b[3:0];
            if (wrem_q == acc_b) st_n = ST_WBACK;
          end
        end
      end
      default: begin
        st_n  = ST_IDLE;
        err_n = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      ch_q    <= '0;
      src_q   <= '0;
      dst_q   <= '0;
      cnt_q   <= '0;
      ssz_q   <= '0;
      dsz_q   <= '0;
      rrem_q  <= '0;
      wrem_q  <= '0;
      fill_q  <= '0;
      drain_q <= '0;
      err_q   <= 1'b0;
    end else begin
      st_q    <= st_n;
      ch_q    <= ch_n;
      src_q   <= src_n;
      dst_q   <= dst_n;
      cnt_q   <= cnt_n;
      ssz_q   <= ssz_n;
      dsz_q   <= dsz_n;
      rrem_q  <= rrem_n;
      wrem_q  <= wrem_n;
      fill_q  <= fill_n;
      drain_q <= drain_n;
      err_q   <= err_n;
    end
  end

  // staging buffer: data path only, loaded under its own enable
  always_ff @(posedge clk) begin
    if (buf_we) begin
      for (int i = 0; i < BUF_BYTES; i++) begin
        if (5'(i) < acc_b) buf_q[4'(fill_q + 4'(i))] <= mem_rdata[8*i +: 8];
      end
    end
  end

  always_comb begin
    for (int i = 0; i < BUF_BYTES; i++) begin
      mem_wdata[8*i +: 8] = (5'(i) < acc_b) ? buf_q[4'(drain_q + 4'(i))] : 8'h00;
    end
  end

  assign idle     = (st_q == ST_IDLE);
  assign mem_req  = (st_q == ST_READ) || (st_q == ST_WRITE);
  assign mem_we   = (st_q == ST_WRITE);
  assign mem_addr = (st_q == ST_WRITE) ? dst_q : src_q;
  assign mem_size = acc_sz;
  assign wb_valid = (st_q == ST_WBACK);
  assign wb_ch    = ch_q;
  assign wb_src   = src_q;
  assign wb_dst   = dst_q;
  assign wb_cnt   = cnt_q;
  assign wb_err   = err_q;

  // R3
  addr_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> ((mem_addr[3:0] & 4'(size_bytes(mem_size) - 5'd1)) == 4'd0));

  // R3
  buf_fit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_we) |-> ((5'(fill_q) + size_bytes(mem_size)) <= 5'd16));

  // R8
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(wb_ch)));

  // R12
  err_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_ack && mem_err) |=> !mem_req);

endmodule

// File: rtl/dma4_buf_engine.sv
module dma4_buf_engine
  import dma4_pkg::*;
#(
  parameter  int NCH = 4,
  parameter  int AW  = 32,
  parameter  int CW  = 16,
  localparam int CHW = $clog2(NCH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rr_en,
  input  logic [NCH-1:0]    dreq,
  input  logic              cfg_we,
  input  logic [CHW-1:0]    cfg_ch,
  input  logic [1:0]        cfg_sel,
  input  logic [AW-1:0]     cfg_wdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [AW-1:0]     mem_addr,
  output logic [1:0]        mem_size,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              mem_ack,
  input  logic              mem_err,
  output logic [NCH-1:0]    ch_busy,
  output logic [NCH-1:0]    ch_done,
  output logic [NCH-1:0]    ch_cfg_err,
  output logic [NCH-1:0]    ch_bus_err,
  output logic [NCH-1:0]    ch_irq
);

  logic [1:0]     rst_sync_q;
  logic           rst_n_s;
  logic [AW-1:0]  c_src [NCH];
  logic [AW-1:0]  c_dst [NCH];
  logic [CW-1:0]  c_cnt [NCH];
  ctrl_t          c_ctrl [NCH];
  logic [NCH-1:0] elig, gnt, gnt_pulse;
  logic [CHW-1:0] gidx;
  logic           eng_idle, start;
  logic           wb_v, wb_e;
  logic [CHW-1:0] wb_ch;
  logic [AW-1:0]  wb_s, wb_d;
  logic [CW-1:0]  wb_c;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    dma4_chan #(.AW(AW), .CW(CW)) u_chan (
      .clk      (clk),
      .rst_n    (rst_n_s),
      .wr_en    (cfg_we && cfg_ch == CHW'(g)),
      .wr_sel   (cfg_sel),
      .wr_data  (cfg_wdata),
      .dreq     (dreq[g]),
      .gnt      (gnt_pulse[g]),
      .wb_valid (wb_v && wb_ch == CHW'(g)),
      .wb_src   (wb_s),
      .wb_dst   (wb_d),
      .wb_cnt   (wb_c),
      .wb_err   (wb_e),
      .src      (c_src[g]),
      .dst      (c_dst[g]),
      .cnt      (c_cnt[g]),
      .ctrl     (c_ctrl[g]),
      .elig     (elig[g]),
      .done     (ch_done[g]),
      .cfg_err  (ch_cfg_err[g]),
      .bus_err  (ch_bus_err[g]),
      .busy     (ch_busy[g]),
      .irq      (ch_irq[g])
    );
  end

  dma4_arb #(.NCH(NCH), .CHW(CHW)) u_arb (
    .clk   (clk),
    .rst_n (rst_n_s),
    .req   (elig),
    .rr_en (rr_en),
    .take  (start),
    .gnt   (gnt)
  );

  assign start     = eng_idle && (|elig);
  assign gnt_pulse = start ? gnt : '0;

  always_comb begin
    gidx = '0;
    for (int k = 0; k < NCH; k++) begin
      if (gnt[k]) gidx = CHW'(k);
    end
  end

  dma4_engine #(.AW(AW), .CW(CW), .CHW(CHW)) u_eng (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .start     (start),
    .start_ch  (gidx),
    .ld_src    (c_src[gidx]),
    .ld_dst    (c_dst[gidx]),
    .ld_cnt    (c_cnt[gidx]),
    .ld_ssz    (c_ctrl[gidx].ssz),
    .ld_dsz    (c_ctrl[gidx].dsz),
    .ld_align  (c_ctrl[gidx].align),
    .idle      (eng_idle),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_size  (mem_size),
    .mem_wdata (mem_wdata),
    .mem_rdata (mem_rdata),
    .mem_ack   (mem_ack),
    .mem_err   (mem_err),
    .wb_valid  (wb_v),
    .wb_ch     (wb_ch),
    .wb_src    (wb_s),
    .wb_dst    (wb_d),
    .wb_cnt    (wb_c),
    .wb_err    (wb_e)
  );

  // R8
  grant_idle_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (|gnt_pulse) |=> mem_req);

endmodule

// File: tb/tb_dma4_buf_engine.sv
module tb_dma4_buf_engine;
  import dma4_pkg::*;

  localparam int MASK = 8191;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         rr_en = 1'b0;
  logic [3:0]   dreq = '0;
  logic         cfg_we = 1'b0;
  logic [1:0]   cfg_ch = '0;
  logic [1:0]   cfg_sel = '0;
  logic [31:0]  cfg_wdata = '0;
  logic         mem_req, mem_we;
  logic [31:0]  mem_addr;
  logic [1:0]   mem_size;
  logic [127:0] mem_wdata, mem_rdata;
  logic         mem_ack = 1'b0;
  logic         mem_err;
  logic [3:0]   ch_busy, ch_done, ch_cfg_err, ch_bus_err, ch_irq;

  logic [7:0]   mem [0:MASK];
  logic [31:0]  wlog_a [0:511];
  logic [1:0]   wlog_s [0:511];
  logic [1:0]   rlog_s [0:511];
  int           wn = 0, rn = 0, misalign = 0;
  logic         err_on = 1'b0;
  logic [31:0]  err_addr = '0;
  int           errors = 0, checks = 0;
  bit           finished = 0;

  always #2 clk = ~clk;

  dma4_buf_engine dut (
    .clk(clk), .rst_n(rst_n), .rr_en(rr_en), .dreq(dreq),
    .cfg_we(cfg_we), .cfg_ch(cfg_ch), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_size(mem_size),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack), .mem_err(mem_err),
    .ch_busy(ch_busy), .ch_done(ch_done), .ch_cfg_err(ch_cfg_err),
    .ch_bus_err(ch_bus_err), .ch_irq(ch_irq)
  );

  function automatic int nbytes(input logic [1:0] c);
    return (c == 2'd3) ? 16 : (1 << c);
  endfunction

  function automatic logic [7:0] pat(input int a);
    return 8'(a * 13 + (a >> 5) + 1);
  endfunction

  assign mem_err = mem_ack && err_on && (mem_addr == err_addr);

  always_comb begin
    for (int i = 0; i < 16; i++)
      mem_rdata[8*i +: 8] = (i < nbytes(mem_size)) ? mem[(int'(mem_addr) + i) & MASK] : 8'h00;
  end

  // memory model and bus monitor
  always @(posedge clk) begin
    if (mem_req && mem_ack && !mem_err) begin
      if ((int'(mem_addr) % nbytes(mem_size)) != 0) misalign++;
      if (mem_we) begin
        for (int i = 0; i < nbytes(mem_size); i++)
          mem[(int'(mem_addr) + i) & MASK] = mem_wdata[8*i +: 8];
        if (wn < 512) begin wlog_a[wn] = mem_addr; wlog_s[wn] = mem_size; end
        wn++;
      end else begin
        if (rn < 512) rlog_s[rn] = mem_size;
        rn++;
      end
    end
    mem_ack <= mem_req && !mem_ack;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wreg(input int ch, input int sel, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_ch = 2'(ch); cfg_sel = 2'(sel); cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  function automatic logic [31:0] mkctl(input bit en, input bit cont, input int ssz,
                                        input int dsz, input bit align, input bit ie);
    return {24'd0, ie, align, 2'(dsz), 2'(ssz), cont, en};
  endfunction

  task automatic prog(input int ch, input int s, input int d, input int n, input logic [31:0] c);
    wreg(ch, 0, 32'(s));
    wreg(ch, 1, 32'(d));
    wreg(ch, 2, 32'(n));
    wreg(ch, 3, c);
  endtask

  task automatic pulse(input logic [3:0] m);
    @(negedge clk);
    dreq = dreq | m;
    cyc(2);
    dreq = dreq & ~m;
  endtask

  task automatic wait_end(input int ch);
    for (int i = 0; i < 3000; i++) begin
      if (ch_done[ch] || ch_bus_err[ch]) break;
      @(negedge clk);
    end
  endtask

  task automatic chk_copy(input int s, input int d, input int n, input string req);
    int bad = 0;
    int first = -1;
    for (int i = 0; i < n; i++) begin
      if (mem[(d + i) & MASK] != pat(s + i)) begin
        bad++;
        if (first < 0) first = i;
      end
    end
    chk(bad == 0, req, "copied bytes mismatching", bad, 0);
  endtask

  task automatic clr_logs();
    @(negedge clk);
    wn = 0; rn = 0; misalign = 0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(ch_busy == 0 && ch_done == 0, "R1", "busy/done after reset", {ch_busy, ch_done}, 0);
    chk(ch_cfg_err == 0 && ch_bus_err == 0, "R1", "error flags after reset", {ch_cfg_err, ch_bus_err}, 0);
    chk(ch_irq == 0 && mem_req == 0, "R1", "irq/mem_req after reset", {ch_irq, 3'b0, mem_req}, 0);
  endtask

  task automatic t_copy();
    clr_logs();
    prog(0, 'h100, 'h200, 32, mkctl(1, 1, 2, 2, 0, 1));
    chk(ch_busy[0] == 1'b1, "R6", "armed before request", ch_busy[0], 1);
    pulse(4'b0001);
    wait_end(0);
    cyc(2);
    chk(ch_done[0] && !ch_busy[0], "R4", "done and idle at count zero", {ch_done[0], ch_busy[0]}, 2);
    chk(ch_irq[0] == 1'b1, "R4", "irq with enable set", ch_irq[0], 1);
    chk(wn == 8, "R6", "writes from one request", wn, 8);
    chk_copy('h100, 'h200, 32, "R2");
    chk(misalign == 0, "R3", "misaligned accesses", misalign, 0);
  endtask

  task automatic t_clear();
    wreg(0, 3, mkctl(0, 1, 2, 2, 0, 1));
    @(negedge clk);
    chk(!ch_done[0] && !ch_irq[0], "R13", "done/irq after control write", {ch_done[0], ch_irq[0]}, 0);
  endtask

  task automatic t_widths();
    int n16 = 0;
    int n2 = 0;
    clr_logs();
    prog(1, 'h300, 'h400, 32, mkctl(1, 1, 0, 3, 0, 0));
    pulse(4'b0010);
    wait_end(1);
    cyc(2);
    chk(rn == 32 && wn == 2, "R3", "1-byte reads / 16-byte writes", rn * 100 + wn, 3202);
    for (int i = 0; i < wn && i < 512; i++) if (wlog_s[i] == 2'd3) n16++;
    chk(n16 == 2, "R2", "size code 3 on writes", n16, 2);
    chk(ch_done[1] && !ch_irq[1], "R4", "done without irq when disabled", {ch_done[1], ch_irq[1]}, 2);
    chk_copy('h300, 'h400, 32, "R3");
    clr_logs();
    prog(2, 'h800, 'h900, 32, mkctl(1, 1, 3, 1, 0, 0));
    pulse(4'b0100);
    wait_end(2);
    cyc(2);
    for (int i = 0; i < wn && i < 512; i++) if (wlog_s[i] == 2'd1) n2++;
    chk(rn == 2 && wn == 16 && n2 == 16, "R3", "16-byte reads / 2-byte writes", rn * 100 + n2, 216);
    chk_copy('h800, 'h900, 32, "R2");
  endtask

  task automatic t_cfg_err();
    clr_logs();
    prog(2, 'hA00, 'hB00, 6, mkctl(1, 1, 2, 2, 0, 0));
    @(negedge clk);
    chk(ch_cfg_err[2] && !ch_busy[2], "R5", "count not multiple", {ch_cfg_err[2], ch_busy[2]}, 2);
    pulse(4'b0100);
    cyc(20);
    chk(rn == 0 && wn == 0, "R5", "accesses after config error", rn + wn, 0);
    prog(2, 'h1002, 'hB00, 8, mkctl(1, 1, 2, 2, 0, 0));
    @(negedge clk);
    chk(ch_cfg_err[2] == 1'b1, "R5", "misaligned source", ch_cfg_err[2], 1);
    prog(2, 'hA00, 'hB00, 0, mkctl(1, 1, 2, 2, 1, 0));
    @(negedge clk);
    chk(ch_cfg_err[2] == 1'b1, "R5", "zero count", ch_cfg_err[2], 1);
  endtask

  task automatic t_steal();
    clr_logs();
    prog(3, 'h1100, 'h1200, 16, mkctl(1, 0, 2, 2, 0, 0));
    pulse(4'b1000);
    cyc(30);
    chk(wn == 1 && ch_busy[3] && !ch_done[3], "R7", "one chunk per edge", wn, 1);
    for (int k = 0; k < 3; k++) begin
      pulse(4'b1000);
      cyc(20);
    end
    chk(wn == 4 && ch_done[3], "R7", "four edges finish 16 bytes", wn, 4);
    chk_copy('h1100, 'h1200, 16, "R7");
  endtask

  task automatic t_prio_mid();
    int ok = 1;
    clr_logs();
    prog(0, 'hC00, 'hC80, 4, mkctl(1, 1, 2, 2, 0, 0));
    prog(2, 'hA00, 'hB00, 32, mkctl(1, 1, 3, 0, 0, 0));
    pulse(4'b0100);
    for (int i = 0; i < 200 && rn < 1; i++) @(negedge clk);
    pulse(4'b0001);
    wait_end(2);
    wait_end(0);
    cyc(4);
    for (int i = 0; i < 16; i++) if (wlog_a[i] != 32'('hB00 + i)) ok = 0;
    chk(ok == 1, "R8", "first chunk not interleaved", ok, 1);
    chk(wlog_a[16] == 32'hC80, "R8", "grant at chunk boundary", wlog_a[16], 'hC80);
    chk(wn == 33, "R8", "total writes", wn, 33);
    chk_copy('hA00, 'hB00, 32, "R8");
  endtask

  task automatic t_prio_fixed();
    clr_logs();
    prog(1, 'h1300, 'h1340, 8, mkctl(1, 1, 2, 2, 0, 0));
    prog(3, 'h1380, 'h13C0, 8, mkctl(1, 1, 2, 2, 0, 0));
    pulse(4'b1010);
    wait_end(3);
    cyc(4);
    chk(wlog_a[0] == 32'h1340 && wlog_a[1] == 32'h1344, "R8", "channel 1 first", wlog_a[1], 'h1344);
    chk(wlog_a[2] == 32'h13C0 && wlog_a[3] == 32'h13C4, "R8", "channel 3 after", wlog_a[3], 'h13C4);
  endtask

  task automatic t_rr();
    clr_logs();
    rr_en = 1'b1;
    prog(0, 'h1400, 'h1500, 8, mkctl(1, 1, 2, 2, 0, 0));
    prog(1, 'h1480, 'h1580, 8, mkctl(1, 1, 2, 2, 0, 0));
    pulse(4'b0011);
    wait_end(0);
    wait_end(1);
    cyc(4);
    chk(wlog_a[0] == 32'h1500 && wlog_a[1] == 32'h1580, "R9", "rotation first pair", wlog_a[1], 'h1580);
    chk(wlog_a[2] == 32'h1504 && wlog_a[3] == 32'h1584, "R9", "rotation second pair", wlog_a[3], 'h1584);
    rr_en = 1'b0;
  endtask

  task automatic t_align();
    clr_logs();
    prog(0, 'h1601, 'h1703, 21, mkctl(1, 1, 3, 3, 1, 0));
    chk(!ch_cfg_err[0] && ch_busy[0], "R10", "odd count accepted", {ch_cfg_err[0], ch_busy[0]}, 1);
    pulse(4'b0001);
    wait_end(0);
    cyc(2);
    chk(ch_done[0] == 1'b1, "R10", "done", ch_done[0], 1);
    chk(rlog_s[0] == 2'd0 && rlog_s[1] == 2'd1 && rlog_s[2] == 2'd2, "R10", "stepped read sizes",
        {rlog_s[0], rlog_s[1], rlog_s[2]}, 6'b000110);
    chk(misalign == 0, "R10", "misaligned accesses", misalign, 0);
    chk_copy('h1601, 'h1703, 21, "R10");
  endtask

  task automatic t_ignore();
    wreg(1, 3, 32'd0);
    clr_logs();
    wreg(1, 0, 32'h1800);
    wreg(1, 1, 32'h1900);
    wreg(1, 2, 32'd8);
    pulse(4'b0010);
    wreg(1, 3, mkctl(1, 1, 2, 2, 0, 0));
    cyc(40);
    chk(rn == 0 && ch_busy[1] && !ch_done[1], "R11", "edge while unarmed dropped", rn, 0);
    pulse(4'b0010);
    wait_end(1);
    cyc(2);
    chk(ch_done[1] == 1'b1, "R11", "later edge runs", ch_done[1], 1);
    chk_copy('h1800, 'h1900, 8, "R11");
  endtask

  task automatic t_bus_err();
    int r0;
    clr_logs();
    err_on = 1'b1;
    err_addr = 32'h1A04;
    prog(0, 'h1A00, 'h1B00, 16, mkctl(1, 1, 2, 2, 0, 0));
    pulse(4'b0001);
    wait_end(0);
    cyc(2);
    chk(ch_bus_err[0] && !ch_done[0] && !ch_busy[0], "R12", "bus error stop",
        {ch_bus_err[0], ch_done[0], ch_busy[0]}, 4);
    r0 = rn + wn;
    cyc(30);
    chk(rn + wn == r0 && wn == 1, "R12", "no access after error", rn + wn, r0);
    err_on = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i <= MASK; i++) mem[i] = pat(i);
    cyc(3);
    rst_n = 1'b1;
    cyc(4);
    t_reset();
    t_copy();
    t_clear();
    t_widths();
    t_cfg_err();
    t_steal();
    t_prio_mid();
    t_prio_fixed();
    t_rr();
    t_align();
    t_ignore();
    t_bus_err();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule